// File: doc/BRIEF.md
# Ping-Pong Capture DMA Channel

This block carries converter results into memory, one 16-bit word per result, while alternating between two buffers. Software programs two base addresses and a block length, then strobes a re-arm input. The channel then waits for result-ready edges. Each edge moves the current result into the selected buffer and advances the destination by one word. When the programmed number of words has been written, the channel disarms and pulses a block-done interrupt.

Software must re-arm the channel before the next result arrives. Each re-arm points the channel at the buffer not used by the previous block. While one buffer fills, the other can be read out safely. An output shows which buffer is being filled.

The trigger is edge-sensitive. A result whose edge arrives while the channel is disarmed, or while it is still moving the previous word, is dropped, and a sticky flag records the loss. A stall input models a processor holding the memory port. Each stalled cycle lengthens the transfer in progress by one cycle.

Top module: `pingpong_capture`

## Requirements
- R1: After reset the channel is disarmed, the active-buffer output is 0, and the missed flag, write enable and block-done output are all 0.
- R2: A re-arm strobe while disarmed with a non-zero count arms the channel on the buffer opposite to the one used by the previous block, or on buffer 0 for the first block after reset. From the next cycle the write address equals that buffer's base address, and the missed flag reads 0.
- R3: Each trigger rising edge accepted while armed and idle produces exactly one memory write. Write k of a block (counted from 0) goes to base + 2*k, and its data is the 12-bit result zero-extended to 16 bits.
- R4: When a trigger edge is sampled at clock edge E0 and no stall occurs, write enable is high during the fourth cycle after E0. Each cycle in which the stall input is high during the transfer delays the write by one cycle, and write enable is never high while stall is high.
- R5: The cycle after the write that completes the programmed count, block-done is high for exactly one cycle and the channel reads disarmed.
- R6: A trigger edge that arrives while the channel is disarmed, or while a transfer is in progress, writes nothing and sets the missed flag. The flag then stays set until the next accepted re-arm.
- R7: A trigger held high for many cycles produces only one transfer, and holding it is not counted as a missed sample.
- R8: A re-arm strobe is ignored while the channel is armed. It is also ignored when the count is 0. In both cases the active buffer and the armed state are unchanged.
- R9: The active-buffer output is stable while the channel is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Result-ready trigger, rising-edge sensitive |
| result_i | input | 12 | Converter result |
| base0_i | input | 16 | Byte base address of buffer 0 |
| base1_i | input | 16 | Byte base address of buffer 1 |
| count_i | input | 16 | Words per block, sampled at re-arm |
| rearm_i | input | 1 | Re-arm strobe |
| stall_i | input | 1 | Memory port held by another master |
| mem_addr_o | output | 16 | Write byte address |
| mem_data_o | output | 16 | Write data |
| mem_we_o | output | 1 | Write enable |
| active_buf_o | output | 1 | Buffer being filled (0 or 1) |
| armed_o | output | 1 | Channel armed |
| block_done_o | output | 1 | One-cycle block-complete interrupt |
| missed_o | output | 1 | Sticky missed-sample flag |

## Verification
The bench uses the default parameters: 12-bit results padded to 16-bit words, a 4-cycle transfer, and 16-bit addresses and counts. It programs blocks of 4, 2 and 1 words. Short blocks reach the block boundary, the buffer alternation and the restart at buffer 0 within a few hundred cycles. Stall lengths of 0 to 2 cycles make the transfer latency visible at the ports. The length of a full 65535-word block is not exercised.

// File: rtl/pp_pkg.sv
// Shared types for the ping-pong capture channel.
package pp_pkg;
    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_BUSY = 1'b1
    } xf_state_t;
endpackage

// File: rtl/pp_edge_det.sv
// Rising-edge detector for the result-ready trigger.
// Assumes trig_i is already synchronous to clk.
module pp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_q;

    // Remember the previous trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/pp_xfer_engine.sv
// Single-word transfer engine. It latches a result on start and then counts
// XFER_CYC unstalled cycles. The write strobe is given in the last of those cycles.
// Assumes start is only raised while idle.
module pp_xfer_engine #(
    parameter int DATA_W   = 16,
    parameter int RES_W    = 12,
    parameter int XFER_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [RES_W-1:0]  result_i,
    input  logic              stall_i,
    output logic              busy_o,
    output logic              we_o,
    output logic [DATA_W-1:0] data_o
);
    import pp_pkg::*;

    localparam int PH_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(XFER_CYC - 1);

    xf_state_t        state;
    logic [PH_W-1:0]  phase;
    logic [RES_W-1:0] res_q;

    // Sequence one transfer: latch, count phases, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XF_IDLE;
            phase <= '0;
            res_q <= '0;
        end else begin
            case (state)
                XF_IDLE: begin
                    if (start_i) begin
                        state <= XF_BUSY;
                        phase <= '0;
                        res_q <= result_i;
                    end
                end
                XF_BUSY: begin
                    if (!stall_i) begin
                        if (phase == PH_LAST) state <= XF_IDLE;
                        else                  phase <= phase + PH_W'(1);
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    assign busy_o = (state == XF_BUSY);
    assign we_o   = busy_o && (phase == PH_LAST) && !stall_i;

    // Pad or truncate the result to the memory word width.
    generate
        if (DATA_W > RES_W) begin : g_pad
            assign data_o = {{(DATA_W - RES_W){1'b0}}, res_q};
        end else begin : g_trunc
            assign data_o = res_q[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/pp_buf_ctrl.sv
// Buffer and arming control. It handles arm and disarm, ping-pong buffer
// selection, destination address, remaining count, the missed flag and
// block-done. Assumes commit_i pulses once per completed word while armed.
module pp_buf_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rearm_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] base0_i,
    input  logic [ADDR_W-1:0] base1_i,
    input  logic              rise_i,
    input  logic              busy_i,
    input  logic              commit_i,
    output logic              start_o,
    output logic              armed_o,
    output logic              active_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              missed_o,
    output logic              done_o
);
    logic             next_buf;
    logic [CNT_W-1:0] remain;
    logic             rearm_ok;
    logic             miss_evt;

    assign rearm_ok = rearm_i && !armed_o && (count_i != '0);
    assign start_o  = rise_i && armed_o && !busy_i;
    assign miss_evt = rise_i && (!armed_o || busy_i);

    // Arm, advance per word, disarm at block end, and track lost triggers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_o  <= 1'b0;
            next_buf <= 1'b0;
            active_o <= 1'b0;
            addr_o   <= '0;
            remain   <= '0;
            missed_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (rearm_ok) begin
                armed_o  <= 1'b1;
                active_o <= next_buf;
                next_buf <= ~next_buf;
                addr_o   <= next_buf ? base1_i : base0_i;
                remain   <= count_i;
                missed_o <= 1'b0;
            end else if (commit_i) begin
                addr_o <= addr_o + ADDR_W'(STEP);
                remain <= remain - CNT_W'(1);
                if (remain == CNT_W'(1)) begin
                    armed_o <= 1'b0;
                    done_o  <= 1'b1;
                end
            end
            if (miss_evt) missed_o <= 1'b1;
        end
    end
endmodule

// File: rtl/pingpong_capture.sv
// Top of the ping-pong capture DMA channel. It connects the trigger edge
// detector, the buffer control and the transfer engine.
// Assumes all inputs are synchronous to clk.
module pingpong_capture #(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int RES_W    = 12,
    parameter int XFER_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [RES_W-1:0]  result_i,
    input  logic [ADDR_W-1:0] base0_i,
    input  logic [ADDR_W-1:0] base1_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              rearm_i,
    input  logic              stall_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              mem_we_o,
    output logic              active_buf_o,
    output logic              armed_o,
    output logic              block_done_o,
    output logic              missed_o
);
    localparam int STEP = DATA_W / 8;

    logic rise;
    logic start;
    logic busy;
    logic commit;

    pp_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (rise)
    );

    pp_buf_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .STEP   (STEP)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rearm_i  (rearm_i),
        .count_i  (count_i),
        .base0_i  (base0_i),
        .base1_i  (base1_i),
        .rise_i   (rise),
        .busy_i   (busy),
        .commit_i (commit),
        .start_o  (start),
        .armed_o  (armed_o),
        .active_o (active_buf_o),
        .addr_o   (mem_addr_o),
        .missed_o (missed_o),
        .done_o   (block_done_o)
    );

    pp_xfer_engine #(
        .DATA_W   (DATA_W),
        .RES_W    (RES_W),
        .XFER_CYC (XFER_CYC)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .result_i (result_i),
        .stall_i  (stall_i),
        .busy_o   (busy),
        .we_o     (commit),
        .data_o   (mem_data_o)
    );

    assign mem_we_o = commit;
endmodule

// File: rtl/pp_capture_chk.sv
// Property checker for pingpong_capture, attached with bind.
// Observes the top-level ports only.
module pp_capture_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int RES_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_i,
    input logic [RES_W-1:0]  result_i,
    input logic [ADDR_W-1:0] base0_i,
    input logic [ADDR_W-1:0] base1_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              rearm_i,
    input logic              stall_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_data_o,
    input logic              mem_we_o,
    input logic              active_buf_o,
    input logic              armed_o,
    input logic              block_done_o,
    input logic              missed_o
);
    localparam int STEP = DATA_W / 8;

    assert_arm_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> (mem_addr_o == (active_buf_o ? $past(base1_i) : $past(base0_i))));

    assert_we_needs_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> armed_o);

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(STEP)));

    assert_no_we_in_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !mem_we_o);

    assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o);

    assert_done_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        block_done_o |-> !armed_o);

    assert_fall_has_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed_o) |-> block_done_o);

    assert_missed_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_o && !rearm_i) |=> missed_o);

    assert_active_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> $stable(active_buf_o));
endmodule

bind pingpong_capture pp_capture_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .RES_W  (RES_W)
) u_chk (.*);

// File: tb/pingpong_capture_tb.sv
module pingpong_capture_tb;
    localparam logic [15:0] BASE0 = 16'h0040;
    localparam logic [15:0] BASE1 = 16'h0100;
    // Table of {stall cycles[15:12], result[11:0]} for one 4-word block.
    localparam logic [15:0] VEC [0:3] = '{16'h0ABC, 16'h2001, 16'h1FFF, 16'h05A5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [11:0] result = '0;
    logic [15:0] base0 = BASE0;
    logic [15:0] base1 = BASE1;
    logic [15:0] count = '0;
    logic        rearm = 1'b0;
    logic        stall = 1'b0;
    logic [15:0] mem_addr;
    logic [15:0] mem_data;
    logic        mem_we;
    logic        active_buf;
    logic        armed;
    logic        block_done;
    logic        missed;

    int checks = 0;
    int fails = 0;
    logic [15:0] bmem [0:255];

    always #5 clk = ~clk;

    pingpong_capture u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig),
        .result_i     (result),
        .base0_i      (base0),
        .base1_i      (base1),
        .count_i      (count),
        .rearm_i      (rearm),
        .stall_i      (stall),
        .mem_addr_o   (mem_addr),
        .mem_data_o   (mem_data),
        .mem_we_o     (mem_we),
        .active_buf_o (active_buf),
        .armed_o      (armed),
        .block_done_o (block_done),
        .missed_o     (missed)
    );

    // Bench memory model fed by the write port.
    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[8:1]] <= mem_data;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_rearm(input logic [15:0] c);
        @(negedge clk);
        rearm = 1'b1;
        count = c;
        @(negedge clk);
        rearm = 1'b0;
    endtask

    // Raise trigger, then watch 16 cycles for writes and block-done.
    task automatic run_trig(input logic [11:0] res, input int stall_n, input int hold,
                            input int reedge, output int nwe, output int lat,
                            output int a, output int d, output int done_at);
        nwe = 0; lat = 0; a = 0; d = 0; done_at = 0;
        @(negedge clk);
        result = res;
        trig = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (mem_we) begin
                nwe++;
                lat = i;
                a = int'(mem_addr);
                d = int'(mem_data);
            end
            if (block_done) done_at = i;
            stall = (i <= stall_n);
            trig = (i < hold) || (i == reedge);
        end
        stall = 1'b0;
        trig = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int nwe, lat, a, d, dn;
        for (int i = 0; i < 256; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 armed", int'(armed), 0);
        chk("R1 active", int'(active_buf), 0);
        chk("R1 missed", int'(missed), 0);
        chk("R1 we", int'(mem_we), 0);
        chk("R1 done", int'(block_done), 0);
        rst_n = 1'b1;

        // R2 first arm uses buffer 0
        do_rearm(16'd4);
        chk("R2 armed", int'(armed), 1);
        chk("R2 active", int'(active_buf), 0);
        chk("R2 addr", int'(mem_addr), int'(BASE0));

        // Table walk: one 4-word block with varied stall (R3, R4, R5)
        for (int k = 0; k < 4; k++) begin
            int st;
            st = int'(VEC[k][15:12]);
            run_trig(VEC[k][11:0], st, 1, 0, nwe, lat, a, d, dn);
            chk("R3 one write", nwe, 1);
            chk("R4 latency", lat, 4 + st);
            chk("R3 addr", a, int'(BASE0) + 2 * k);
            chk("R3 data", d, int'({4'h0, VEC[k][11:0]}));
            chk("R5 done timing", dn, (k == 3) ? lat + 1 : 0);
        end
        chk("R5 disarmed", int'(armed), 0);
        for (int k = 0; k < 4; k++)
            chk("R3 memory", int'(bmem[8'd32 + 8'(k)]), int'({4'h0, VEC[k][11:0]}));

        // R6 trigger while disarmed
        run_trig(12'h123, 0, 1, 0, nwe, lat, a, d, dn);
        chk("R6 no write", nwe, 0);
        chk("R6 missed set", int'(missed), 1);

        // R2 second block uses buffer 1 and clears missed
        do_rearm(16'd2);
        chk("R2 active alt", int'(active_buf), 1);
        chk("R2 addr alt", int'(mem_addr), int'(BASE1));
        chk("R2 missed clr", int'(missed), 0);

        // R8 re-arm while armed ignored
        do_rearm(16'd5);
        chk("R8 active kept", int'(active_buf), 1);
        chk("R8 addr kept", int'(mem_addr), int'(BASE1));

        // R7 held trigger gives one transfer, no miss
        run_trig(12'h7E1, 0, 12, 0, nwe, lat, a, d, dn);
        chk("R7 one write", nwe, 1);
        chk("R7 no miss", int'(missed), 0);
        chk("R9 active stable", int'(active_buf), 1);

        // R6 second edge during the transfer is lost
        run_trig(12'h0F0, 0, 1, 2, nwe, lat, a, d, dn);
        chk("R6 busy one write", nwe, 1);
        chk("R6 busy addr", a, int'(BASE1) + 2);
        chk("R6 busy missed", int'(missed), 1);
        chk("R5 done count 2", dn, lat + 1);
        chk("R5 disarmed 2", int'(armed), 0);

        // R8 zero count ignored
        do_rearm(16'd0);
        chk("R8 zero count", int'(armed), 0);
        chk("R8 zero active", int'(active_buf), 1);

        // R2 third block returns to buffer 0
        do_rearm(16'd1);
        chk("R2 back to 0", int'(active_buf), 0);
        chk("R2 addr restart", int'(mem_addr), int'(BASE0));
        chk("R6 cleared", int'(missed), 0);
        run_trig(12'hC3A, 1, 1, 0, nwe, lat, a, d, dn);
        chk("R4 stall latency", lat, 5);
        chk("R3 data pad", d, 16'h0C3A);
        chk("R5 single block", dn, lat + 1);

        summary();
    end
endmodule